// File: doc/BRIEF.md
# Capture/Compare Timer Array

The block provides one free-running 16-bit time base and several identical channels (five by default) that share it. A small byte-wide register port configures the block. It selects the clock source for the time base, starts and stops it, and programs each channel. Each channel has a mode register. With it a channel can latch the count on a rising and/or falling edge of its input pin. It can also raise a flag on a 16-bit match, toggle its output pin on that match, or generate an 8-bit pulse-width-modulated output.

The PWM output is glitch-free. The duty byte is held in the channel's high register and is copied into the active low register only when the low count byte wraps from FFh to 00h. Overflow and channel events set sticky flags, which are cleared by software only. The flags, gated by their enables, are ORed into a single interrupt request. When the watchdog enable is set, a match on the last channel raises a one-cycle system reset request.

Top module: `cap_cmp_array`

## Requirements
- R1: The 16-bit count (CNTL address 02h low byte, CNTH address 03h high byte) advances by one on each selected tick only while the run bit (CTRL address 00h, bit 0) is 1. It holds its value otherwise. A byte write to either count address replaces that byte.
- R2: The clock select field (CTRL bits 2:1) chooses the tick source. Code 0 gives one tick every 12 clocks from a divider that runs from reset. Code 1 gives one tick every 4 clocks, on the same divider, when the divider is at 3, 7 and 11. Code 2 gives a tick in every clock in which `t0_ovf` is high. Code 3 gives a tick on each rising edge of `ext_clk`.
- R3: A tick taken while the count is FFFFh wraps the count to 0000h and sets the overflow flag, bit 7 of FLAGS (address 01h).
- R4: The mode register of channel n is at address 08h+n. Its bits are: 6 comparator enable, 5 rising-edge capture, 4 falling-edge capture, 3 match, 2 toggle, 1 PWM, 0 interrupt enable. Every register of the block reads as zero after reset.
- R5: A selected edge on `cap_in[n]` copies the count into the channel's register pair (low byte at 10h+n, high byte at 18h+n) and sets FLAGS bit n.
- R6: When comparator enable and match are both set, a tick taken while the count equals the 16-bit pair sets FLAGS bit n. If toggle is also set, the same event inverts `cmp_out[n]`.
- R7: A write to the low byte at 10h+n clears the comparator enable of channel n, and a write to the high byte at 18h+n sets it.
- R8: When comparator enable and PWM are both set, `cmp_out[n]` is 0 while the count low byte is below the low register and 1 when it is equal or greater. A tick that wraps the count low byte from FFh to 00h loads the low register from the high register.
- R9: When the watchdog enable (CTRL bit 4) is set, a match event on the last channel drives `wdog_rst` high for exactly the following clock cycle.
- R10: `irq` is high whenever the overflow flag is set together with the overflow enable (CTRL bit 3), or any channel flag is set together with that channel's interrupt-enable bit.
- R11: Flags are cleared only by a write to FLAGS, where a 0 in a bit position clears that flag and a 1 leaves it. A hardware set in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| t0_ovf | input | 1 | External timer overflow pulse (tick source 2) |
| ext_clk | input | 1 | External count pin (tick source 3) |
| cap_in | input | NUM_SLOTS | Channel capture pins |
| cmp_out | output | NUM_SLOTS | Channel output pins |
| irq | output | 1 | Combined interrupt request |
| wdog_rst | output | 1 | Watchdog reset request pulse |

## Verification
The bench targets the FFFFh wrap. A design that compared against the wrong terminal count would miss the overflow flag or set it one tick early. It drives PWM across several low-byte wraps while the duty byte changes. A design that reloaded immediately or on the wrong wrap would show a glitch or a stale duty in the per-clock comparison. It writes the compare bytes in both orders and reads back the comparator enable, which exposes a swapped or missing side effect. It also clears flags with mixed masks, which catches clear-on-one polarity errors and a hardware set that loses to a software clear.

// File: rtl/cca_pkg.sv
package cca_pkg;
  localparam int CNT_W = 16;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] A_FLAGS = 5'h01;
  localparam logic [ADDR_W-1:0] A_CNTL  = 5'h02;
  localparam logic [ADDR_W-1:0] A_CNTH  = 5'h03;
  localparam logic [ADDR_W-1:0] A_MODE  = 5'h08;
  localparam logic [ADDR_W-1:0] A_CAPL  = 5'h10;
  localparam logic [ADDR_W-1:0] A_CAPH  = 5'h18;

  typedef struct packed {
    logic ecom;
    logic capp;
    logic capn;
    logic mat;
    logic tog;
    logic pwm;
    logic ie;
  } mode_t;

  typedef struct packed {
    logic       wdog_en;
    logic       ovf_ie;
    logic [1:0] clk_sel;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/cca_timebase.sv
module cca_timebase
  import cca_pkg::*;
#(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       clk_sel,
  input  logic             t0_ovf,
  input  logic             ext_clk,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_en,
  output logic             ovf
);
  localparam int PRE_W = $clog2(DIV_SLOW);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV_SLOW - 1);

  logic [PRE_W-1:0] pre_q, pre_n;
  logic             ext_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_ld;
  logic             tick_slow, tick_fast, tick;

  always_comb begin
    pre_n     = (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
    tick_slow = (pre_q == PRE_LAST);
    tick_fast = ((int'(pre_q) % DIV_FAST) == DIV_FAST - 1);
    case (clk_sel)
      2'd0:    tick = tick_slow;
      2'd1:    tick = tick_fast;
      2'd2:    tick = t0_ovf;
      default: tick = ext_clk & ~ext_q;
    endcase
    cnt_en = run & tick;
    ovf    = cnt_en & (cnt_q == '1);
    cnt_n  = cnt_en ? cnt_q + 1'b1 : cnt_q;
    if (wr_lo) cnt_n[7:0] = wdata;
    if (wr_hi) cnt_n[15:8] = wdata;
    cnt_ld = cnt_en | wr_lo | wr_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ext_q <= 1'b0;
    end else begin
      pre_q <= pre_n;
      ext_q <= ext_clk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_n;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/cca_slot.sv
module cca_slot
  import cca_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_en,
  input  logic             pin_in,
  input  logic             wr_mode,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       wdata,
  output mode_t            mode,
  output logic [7:0]       reg_lo,
  output logic [7:0]       reg_hi,
  output logic             pin_out,
  output logic             flag_set,
  output logic             match_evt
);
  mode_t      mode_q, mode_n;
  logic [7:0] lo_q, lo_n, hi_q, hi_n;
  logic       tog_q, tog_n, pin_q;
  logic       rise, fall, cap_evt, pwm_on, reload;
  logic       mode_ld, lo_ld, hi_ld;

  always_comb begin
    rise      = pin_in & ~pin_q;
    fall      = ~pin_in & pin_q;
    cap_evt   = (mode_q.capp & rise) | (mode_q.capn & fall);
    match_evt = cnt_en & mode_q.ecom & mode_q.mat & (cnt == {hi_q, lo_q});
    pwm_on    = mode_q.ecom & mode_q.pwm;
    reload    = pwm_on & cnt_en & (cnt[7:0] == 8'hFF);

    mode_n = mode_q;
    if (wr_mode) mode_n = mode_t'(wdata[6:0]);
    if (wr_lo)   mode_n.ecom = 1'b0;
    if (wr_hi)   mode_n.ecom = 1'b1;
    mode_ld = wr_mode | wr_lo | wr_hi;

    lo_n = lo_q;
    if (cap_evt) lo_n = cnt[7:0];
    if (reload)  lo_n = hi_q;
    if (wr_lo)   lo_n = wdata;
    lo_ld = cap_evt | reload | wr_lo;

    hi_n = hi_q;
    if (cap_evt) hi_n = cnt[15:8];
    if (wr_hi)   hi_n = wdata;
    hi_ld = cap_evt | wr_hi;

    tog_n    = ~tog_q;
    flag_set = cap_evt | match_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_ld) mode_q <= mode_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_ld) lo_q <= lo_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_ld) hi_q <= hi_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        tog_q <= 1'b0;
    else if (match_evt & mode_q.tog)   tog_q <= tog_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_in;
  end

  assign mode    = mode_q;
  assign reg_lo  = lo_q;
  assign reg_hi  = hi_q;
  assign pin_out = pwm_on ? (cnt[7:0] >= lo_q) : tog_q;
endmodule

// File: rtl/cap_cmp_array.sv
module cap_cmp_array
  import cca_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  parameter int DIV_SLOW  = 12,
  parameter int DIV_FAST  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  input  logic                 t0_ovf,
  input  logic                 ext_clk,
  input  logic [NUM_SLOTS-1:0] cap_in,
  output logic [NUM_SLOTS-1:0] cmp_out,
  output logic                 irq,
  output logic                 wdog_rst
);
  localparam int LAST = NUM_SLOTS - 1;

  ctrl_t                ctrl_q;
  logic [NUM_SLOTS-1:0] mflag_q, mflag_n;
  logic                 ovf_q, ovf_n;
  logic                 wdog_q;
  logic [CNT_W-1:0]     cnt;
  logic                 cnt_en, ovf_evt;
  logic                 wr_ctrl, wr_flags, wr_cntl, wr_cnth;

  logic [NUM_SLOTS-1:0] wr_mode, wr_lo, wr_hi;
  logic [NUM_SLOTS-1:0] slot_set, slot_match, slot_ie;
  mode_t                slot_mode [NUM_SLOTS];
  logic [7:0]           slot_lo   [NUM_SLOTS];
  logic [7:0]           slot_hi   [NUM_SLOTS];

  assign wr_ctrl  = wr_en & (addr == A_CTRL);
  assign wr_flags = wr_en & (addr == A_FLAGS);
  assign wr_cntl  = wr_en & (addr == A_CNTL);
  assign wr_cnth  = wr_en & (addr == A_CNTH);

  cca_timebase #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) tb_i (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .clk_sel(ctrl_q.clk_sel),
    .t0_ovf(t0_ovf), .ext_clk(ext_clk), .wr_lo(wr_cntl), .wr_hi(wr_cnth),
    .wdata(wdata), .cnt(cnt), .cnt_en(cnt_en), .ovf(ovf_evt)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign wr_mode[i] = wr_en & (addr == (A_MODE + ADDR_W'(i)));
    assign wr_lo[i]   = wr_en & (addr == (A_CAPL + ADDR_W'(i)));
    assign wr_hi[i]   = wr_en & (addr == (A_CAPH + ADDR_W'(i)));
    assign slot_ie[i] = slot_mode[i].ie;

    cca_slot slot_i (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_en(cnt_en), .pin_in(cap_in[i]),
      .wr_mode(wr_mode[i]), .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(wdata),
      .mode(slot_mode[i]), .reg_lo(slot_lo[i]), .reg_hi(slot_hi[i]),
      .pin_out(cmp_out[i]), .flag_set(slot_set[i]), .match_evt(slot_match[i])
    );
  end

  always_comb begin
    mflag_n = mflag_q;
    ovf_n   = ovf_q;
    if (wr_flags) begin
      mflag_n = mflag_q & wdata[NUM_SLOTS-1:0];
      ovf_n   = ovf_q & wdata[7];
    end
    mflag_n = mflag_n | slot_set;
    ovf_n   = ovf_n | ovf_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(wdata[4:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mflag_q <= '0;
      ovf_q   <= 1'b0;
      wdog_q  <= 1'b0;
    end else begin
      mflag_q <= mflag_n;
      ovf_q   <= ovf_n;
      wdog_q  <= ctrl_q.wdog_en & slot_match[LAST];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL)  rdata = {3'b000, ctrl_q};
    if (addr == A_FLAGS) begin
      rdata[7]             = ovf_q;
      rdata[NUM_SLOTS-1:0] = mflag_q;
    end
    if (addr == A_CNTL)  rdata = cnt[7:0];
    if (addr == A_CNTH)  rdata = cnt[15:8];
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (addr == (A_MODE + ADDR_W'(i))) rdata = {1'b0, slot_mode[i]};
      if (addr == (A_CAPL + ADDR_W'(i))) rdata = slot_lo[i];
      if (addr == (A_CAPH + ADDR_W'(i))) rdata = slot_hi[i];
    end
  end

  assign irq      = (ovf_q & ctrl_q.ovf_ie) | (|(mflag_q & slot_ie));
  assign wdog_rst = wdog_q;
endmodule

// File: rtl/cca_checks.sv
module cca_checks
  import cca_pkg::*;
#(
  parameter int NUM_SLOTS = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    addr,
  input logic                 irq,
  input logic                 wdog_rst,
  input logic [NUM_SLOTS:0]   flags,
  input logic                 run,
  input logic                 wdog_en,
  input logic [CNT_W-1:0]     cnt
);
  assert_cnt_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(wr_en && (addr == A_CNTL || addr == A_CNTH))) |=> $stable(cnt));

  assert_wdog_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |-> $past(wdog_en));

  assert_wdog_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |=> !wdog_rst);

  assert_irq_has_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0));

  assert_flags_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_FLAGS) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

bind cap_cmp_array cca_checks #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .irq(irq),
  .wdog_rst(wdog_rst), .flags({ovf_q, mflag_q}), .run(ctrl_q.run),
  .wdog_en(ctrl_q.wdog_en), .cnt(cnt)
);

// File: tb/cap_cmp_array_tb.sv
module cap_cmp_array_tb_top;
  localparam int NS = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [4:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          t0_ovf = 1'b0;
  logic          ext_clk = 1'b0;
  logic [NS-1:0] cap_in = '0;
  logic [NS-1:0] cmp_out;
  logic          irq, wdog_rst;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cap_cmp_array dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .t0_ovf(t0_ovf), .ext_clk(ext_clk), .cap_in(cap_in),
    .cmp_out(cmp_out), .irq(irq), .wdog_rst(wdog_rst)
  );

  // behavioural reference state
  int       m_pre;
  int       m_cnt;
  bit       m_ext;
  bit [4:0] m_ctrl;
  bit [NS-1:0] m_flag;
  bit       m_ovf;
  bit       m_wdog;
  bit [6:0] m_mode [NS];
  int       m_lo [NS];
  int       m_hi [NS];
  bit       m_tog [NS];
  bit       m_pin [NS];
  bit       e_cap [NS];
  bit       e_mat [NS];
  bit       e_rel [NS];

  function automatic bit exp_out(int n);
    if (m_mode[n][6] && m_mode[n][1]) return (m_cnt % 256) >= m_lo[n];
    return m_tog[n];
  endfunction

  function automatic bit exp_irq();
    bit r = m_ovf && m_ctrl[3];
    for (int n = 0; n < NS; n++) if (m_flag[n] && m_mode[n][0]) r = 1;
    return r;
  endfunction

  function automatic int exp_read(int a);
    if (a == 0) return m_ctrl;
    if (a == 1) return (m_ovf ? 128 : 0) + m_flag;
    if (a == 2) return m_cnt % 256;
    if (a == 3) return m_cnt / 256;
    for (int n = 0; n < NS; n++) begin
      if (a == 8 + n)  return m_mode[n];
      if (a == 16 + n) return m_lo[n];
      if (a == 24 + n) return m_hi[n];
    end
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_ext = 0; m_ctrl = 0; m_flag = 0; m_ovf = 0; m_wdog = 0;
      for (int n = 0; n < NS; n++) begin
        m_mode[n] = 0; m_lo[n] = 0; m_hi[n] = 0; m_tog[n] = 0; m_pin[n] = 0;
      end
    end else begin
      bit tick, en, ovf;
      case (m_ctrl[2:1])
        2'd0: tick = (m_pre == 11);
        2'd1: tick = (m_pre % 4 == 3);
        2'd2: tick = t0_ovf;
        default: tick = ext_clk && !m_ext;
      endcase
      en  = m_ctrl[0] && tick;
      ovf = en && (m_cnt == 65535);
      for (int n = 0; n < NS; n++) begin
        e_cap[n] = (m_mode[n][5] && cap_in[n] && !m_pin[n]) ||
                   (m_mode[n][4] && !cap_in[n] && m_pin[n]);
        e_mat[n] = en && m_mode[n][6] && m_mode[n][3] && (m_cnt == m_hi[n] * 256 + m_lo[n]);
        e_rel[n] = en && m_mode[n][6] && m_mode[n][1] && (m_cnt % 256 == 255);
      end
      m_wdog = m_ctrl[4] && e_mat[NS-1];
      if (wr_en && addr == 1) begin
        m_flag = m_flag & wdata[NS-1:0];
        m_ovf  = m_ovf && wdata[7];
      end
      if (ovf) m_ovf = 1;
      for (int n = 0; n < NS; n++) begin
        if (e_cap[n] || e_mat[n]) m_flag[n] = 1;
        if (e_mat[n] && m_mode[n][2]) m_tog[n] = !m_tog[n];
        if (e_cap[n]) begin
          m_lo[n] = m_cnt % 256;
          m_hi[n] = m_cnt / 256;
        end
        if (e_rel[n]) m_lo[n] = m_hi[n];
        if (wr_en && addr == 8 + n) m_mode[n] = wdata[6:0];
        if (wr_en && addr == 16 + n) begin
          m_lo[n] = wdata; m_mode[n][6] = 0;
        end
        if (wr_en && addr == 24 + n) begin
          m_hi[n] = wdata; m_mode[n][6] = 1;
        end
        m_pin[n] = cap_in[n];
      end
      if (en) m_cnt = (m_cnt + 1) % 65536;
      if (wr_en && addr == 2) m_cnt = (m_cnt / 256) * 256 + wdata;
      if (wr_en && addr == 3) m_cnt = wdata * 256 + (m_cnt % 256);
      if (wr_en && addr == 0) m_ctrl = wdata[4:0];
      m_pre = (m_pre + 1) % 12;
      m_ext = ext_clk;
    end
  end

  // per-clock comparison of outputs against the reference
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      for (int n = 0; n < NS; n++) begin
        checks++;
        if (cmp_out[n] !== exp_out(n)) begin
          errors++;
          $display("FAIL R6 R8 cmp_out[%0d] actual %0b expected %0b at %0t", n, cmp_out[n], exp_out(n), $time);
        end
      end
      checks++;
      if (irq !== exp_irq()) begin
        errors++;
        $display("FAIL R10 irq actual %0b expected %0b at %0t", irq, exp_irq(), $time);
      end
      checks++;
      if (wdog_rst !== m_wdog) begin
        errors++;
        $display("FAIL R9 wdog_rst actual %0b expected %0b at %0t", wdog_rst, m_wdog, $time);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 5'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    addr = 5'(a);
    #2;
    checks++;
    if (int'(rdata) != exp_read(a)) begin
      errors++;
      $display("FAIL %s addr %0h actual %0h expected %0h", tag, a, rdata, exp_read(a));
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R4 reset values
    rd(0, "R4 ctrl reset");
    rd(1, "R11 flags reset");
    rd(8, "R4 mode0 reset");
    rd(12, "R4 mode4 reset");
    rd(2, "R4 count reset");

    // R1 R2 divide by 4 and by 12
    wr(0, 8'h03);
    idle(40);
    rd(2, "R1 R2 div4 count");
    wr(0, 8'h01);
    idle(50);
    rd(2, "R2 div12 count");
    wr(0, 8'h00);
    idle(10);
    rd(2, "R1 stopped count");

    // R3 overflow via t0_ovf source, R10 overflow irq
    wr(2, 8'hF0);
    wr(3, 8'hFF);
    rd(3, "R1 count high write");
    t0_ovf = 1'b1;
    wr(0, 8'h0D);
    idle(25);
    rd(1, "R3 overflow flag");
    rd(3, "R3 wrapped high byte");
    // R11 clear with mask keeps other bits
    wr(1, 8'h7F);
    rd(1, "R11 clear overflow");

    // R5 capture rising on slot 0, falling on slot 1
    wr(8, 8'h21);
    wr(9, 8'h11);
    idle(3);
    cap_in[0] = 1'b1;
    idle(4);
    rd(16, "R5 capture low slot0");
    rd(24, "R5 capture high slot0");
    cap_in[1] = 1'b1;
    idle(3);
    rd(17, "R5 rising ignored slot1");
    cap_in[1] = 1'b0;
    idle(3);
    rd(17, "R5 falling capture slot1");
    rd(1, "R5 flags after capture");
    wr(1, 8'h02);
    rd(1, "R11 partial clear");

    // R6 R7 compare with toggle on slot 2
    wr(0, 8'h00);
    wr(2, 8'h00);
    wr(3, 8'h10);
    wr(26, 8'h10);
    rd(10, "R7 high write sets enable");
    wr(18, 8'h20);
    rd(10, "R7 low write clears enable");
    wr(26, 8'h10);
    wr(10, 8'h4D);
    wr(0, 8'h05);
    idle(50);
    rd(1, "R6 match flag");
    idle(300);

    // R8 PWM on slot 3 with duty changes
    wr(19, 8'h80);
    wr(27, 8'h40);
    wr(11, 8'h42);
    idle(600);
    wr(27, 8'hC0);
    idle(600);
    wr(27, 8'h00);
    idle(300);
    rd(19, "R8 reloaded low byte");

    // R2 external pin source
    wr(0, 8'h07);
    for (int k = 0; k < 20; k++) begin
      ext_clk = 1'b1; idle(2);
      ext_clk = 1'b0; idle(3);
    end
    rd(2, "R2 external count");

    // R9 watchdog on last slot
    wr(0, 8'h00);
    wr(2, 8'h00);
    wr(3, 8'h30);
    wr(20, 8'h20);
    wr(28, 8'h30);
    wr(12, 8'h48);
    wr(0, 8'h15);
    idle(60);
    rd(1, "R9 last slot match flag");
    wr(1, 8'h00);
    rd(1, "R11 clear all");
    idle(5);
    finish_run();
  end
endmodule